// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block collects up to 32 external interrupt request lines and presents them to a CPU as a single interrupt output. Each implemented channel has a trigger behaviour fixed at build time by two parameter masks: one mask chooses between level and edge sensitivity, and the other chooses the active polarity. When a channel's trigger fires while that channel is enabled, its pending bit is set. Pending bits stay set until software clears them, and disabling the channel does not clear them.

A fixed-priority encoder reports the lowest-numbered pending channel as a 5-bit source ID. Software works through a small word-indexed register interface. It enables channels, reads and clears pending bits, reads the source ID, and acknowledges the interrupt by writing to the source register. The CPU interrupt output is latched. Once it is raised it stays high until the acknowledge write. In the cycle after that write it is low, and it rises again if anything is still pending.

Every request input passes through a two-flop synchronizer before trigger detection. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `irq_gather_ctrl`

## Requirements
- R1: Only the low NUM_CH bits of `irq_in` are channels. Higher input bits never set a pending bit. Enable and pending bits above NUM_CH-1 read as 0, even after software writes ones to them.
- R2: A channel whose edge-mask bit is 1 and polarity bit is 1 becomes pending on a 0-to-1 transition of its input. A steady high input, or a falling input, does not set it again after it is cleared.
- R3: A channel whose edge-mask bit is 1 and polarity bit is 0 becomes pending on a 1-to-0 transition of its input.
- R4: A channel whose edge-mask bit is 0 is level-sensitive. Polarity bit 1 means active-high and 0 means active-low. While the input stays at the active level, the pending bit is set again after it is cleared.
- R5: A trigger on a channel whose enable bit is 0 does not set that channel's pending bit.
- R6: Writing 0 to an enable bit leaves that channel's pending bit set.
- R7: A write to word 1 (pending) clears every pending bit whose write-data bit is 0 and leaves unchanged every bit whose write-data bit is 1. If a trigger fires in the same cycle as the clear, the bit stays set.
- R8: Word 2 (source) reads the index of the lowest-numbered pending channel in bits 4:0, with bits 31:5 zero. It reads 0 when nothing is pending.
- R9: `cpu_irq` rises on the cycle after any pending bit is set. Once high, it stays high until an acknowledge, even if all pending bits are cleared.
- R10: A write of any value to word 2 is the acknowledge. `cpu_irq` is 0 in the next cycle, and rises one cycle later if any channel is still pending.
- R11: A read to word 0 returns the enable bits and a read to word 1 returns the pending bits. A read to word 3 returns 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` is 0 when no read was issued.
- R12: After reset, all enable bits and pending bits are 0 and `cpu_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt request lines; bit i is channel i |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index: 0 enable, 1 pending, 2 source/acknowledge, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Latched interrupt request to the CPU |

## Verification
The hardest situation to reach is the acknowledge dip. At the moment of the acknowledge write, one channel must already have been cleared while another is still pending, so that the output is expected to drop for exactly one cycle and then return. The bench gets there by raising two level-triggered channels and then withdrawing their inputs. It next clears only the lower channel and issues the acknowledge write. It then samples `cpu_irq` on the two following cycles, and repeats the sequence with nothing pending so that the output is expected to stay low. The bench also checks the edge/level distinction directly: it clears a pending bit while the input is held active and checks whether the bit comes back.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 5;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PENDING = 2'd1,
    SEL_SOURCE  = 2'd2,
    SEL_RSVD    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqg_trigger.sv
module irqg_trigger #(
  parameter int unsigned NUM_CH    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0,
  parameter logic [31:0] POL_MASK  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] irq_in,
  output logic [31:0] fire
);
  for (genvar i = 0; i < 32; i++) begin : g_ch
    if (i < NUM_CH) begin : g_on
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= irq_in[i];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end

      if (EDGE_MASK[i]) begin : g_edge
        assign fire[i] = (sync_q == POL_MASK[i]) && (prev_q != POL_MASK[i]);

        // R2
        edge_single_chk: assert property (@(posedge clk) disable iff (rst)
          fire[i] |=> !fire[i]);
      end else begin : g_level
        assign fire[i] = (sync_q == POL_MASK[i]);
      end
    end else begin : g_off
      assign fire[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqg_pending.sv
module irqg_pending #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] fire,
  input  logic        en_we,
  input  logic        pend_we,
  input  logic [31:0] wdata,
  output logic [31:0] en,
  output logic [31:0] pend
);
  localparam logic [31:0] IMPL = 32'((64'd1 << NUM_CH) - 64'd1);

  logic [31:0] kept;

  always_comb begin
    kept = pend_we ? (pend & wdata) : pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      pend <= '0;
    end else begin
      if (en_we) en <= wdata & IMPL;
      pend <= (kept | (fire & en)) & IMPL;
    end
  end

  // R5
  gate_by_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == 32'h0));

  // R6
  hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_we |=> (($past(pend) & ~pend) == 32'h0));

  // R7
  keep_ones_chk: assert property (@(posedge clk) disable iff (rst)
    pend_we |=> (($past(pend) & $past(wdata) & ~pend) == 32'h0));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend | en) & ~IMPL) == 32'h0);
endmodule

// File: rtl/irqg_prio.sv
module irqg_prio (
  input  logic [31:0] pend,
  output logic [4:0]  id,
  output logic        any
);
  always_comb begin
    id = 5'd0;
    for (int i = 31; i >= 0; i--) begin
      if (pend[i]) id = 5'(i);
    end
    any = |pend;
  end

  // R8
  lowest_first_chk: assert final (!any ||
    (pend[id] && ((pend & ~(32'hFFFF_FFFF << id)) == 32'h0)));
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl #(
  parameter int unsigned NUM_CH         = 32,
  parameter logic [31:0] TRIG_EDGE_MASK = 32'h0,
  parameter logic [31:0] TRIG_POL_MASK  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] irq_in,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cpu_irq
);
  import irqg_pkg::*;

  logic [31:0]     fire, en, pend;
  logic [ID_W-1:0] src_id;
  logic            any_pend;
  reg_sel_e        sel;
  logic            en_we, pend_we, ack;
  logic [31:0]     rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign en_we   = bus_wr && (sel == SEL_ENABLE);
  assign pend_we = bus_wr && (sel == SEL_PENDING);
  assign ack     = bus_wr && (sel == SEL_SOURCE);

  irqg_trigger #(
    .NUM_CH(NUM_CH), .EDGE_MASK(TRIG_EDGE_MASK), .POL_MASK(TRIG_POL_MASK)
  ) u_trig (
    .clk(clk), .rst(rst), .irq_in(irq_in), .fire(fire)
  );

  irqg_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst(rst), .fire(fire), .en_we(en_we), .pend_we(pend_we),
    .wdata(bus_wdata), .en(en), .pend(pend)
  );

  irqg_prio u_prio (.pend(pend), .id(src_id), .any(any_pend));

  always_comb begin
    unique case (sel)
      SEL_ENABLE:  rd_mux = en;
      SEL_PENDING: rd_mux = pend;
      SEL_SOURCE:  rd_mux = {{(DATA_W-ID_W){1'b0}}, src_id};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      cpu_irq   <= ack ? 1'b0 : (cpu_irq | any_pend);
    end
  end

  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !cpu_irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && !ack) |=> cpu_irq);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (any_pend && !ack) |=> cpu_irq);

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == 32'h0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 32'h0));
endmodule

// File: tb/tb_irq_gather_ctrl.sv
module tb_irq_gather_ctrl;
  localparam logic [31:0] IDLE = 32'h0000_000A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = IDLE;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  int          n_chk = 0, n_bad = 0;

  // ch0 rising edge, ch1 falling edge, ch2 high level, ch3 low level, ch4..7 high level
  irq_gather_ctrl #(
    .NUM_CH(8), .TRIG_EDGE_MASK(32'h3), .TRIG_POL_MASK(32'hFFFF_FFF5)
  ) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clean();
    irq_in = IDLE;
    settle();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 cpu_irq", {31'h0, cpu_irq}, 32'h0);
    rd(2'd0, d); chk("R12 enable", d, 32'h0);
    rd(2'd1, d); chk("R12 pending", d, 32'h0);
    rd(2'd2, d); chk("R8 source idle", d, 32'h0);
    chk("R11 rdata idle", bus_rdata, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(2'd0, 32'h1);
    irq_in[0] = 1'b1; settle();
    rd(2'd1, d); chk("R2 rise sets", d, 32'h1);
    chk("R9 raised", {31'h0, cpu_irq}, 32'h1);
    wr(2'd1, ~32'h1); settle();
    rd(2'd1, d); chk("R2 steady high no retrigger", d, 32'h0);
    irq_in[0] = 1'b0; settle();
    rd(2'd1, d); chk("R2 falling ignored", d, 32'h0);
    clean();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(2'd0, 32'h2);
    irq_in[1] = 1'b0; settle();
    rd(2'd1, d); chk("R3 fall sets", d, 32'h2);
    wr(2'd1, ~32'h2); settle();
    rd(2'd1, d); chk("R3 steady low no retrigger", d, 32'h0);
    clean();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(2'd0, 32'hC);
    irq_in[2] = 1'b1; irq_in[3] = 1'b0; settle();
    rd(2'd1, d); chk("R4 both levels", d, 32'hC);
    wr(2'd1, 32'h0); settle();
    rd(2'd1, d); chk("R4 level re-pends", d, 32'hC);
    irq_in = IDLE; settle();
    wr(2'd1, 32'h0); settle();
    rd(2'd1, d); chk("R4 inactive level clears", d, 32'h0);
    clean();
  endtask

  task automatic t_gate();
    logic [31:0] d;
    irq_in[0] = 1'b1; irq_in[2] = 1'b1; irq_in[1] = 1'b0; settle();
    irq_in = IDLE; settle();
    rd(2'd1, d); chk("R5 disabled no pend", d, 32'h0);
    chk("R5 no irq", {31'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_keep();
    logic [31:0] d;
    wr(2'd0, 32'h10);
    irq_in[4] = 1'b1; settle();
    irq_in[4] = 1'b0;
    wr(2'd0, 32'h0); settle();
    rd(2'd1, d); chk("R6 kept after disable", d, 32'h10);
    rd(2'd2, d); chk("R8 source 4", d, 32'h4);
    wr(2'd1, 32'hFFFF_FFFF); settle();
    rd(2'd1, d); chk("R7 ones keep", d, 32'h10);
    clean();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(2'd0, 32'hF0);
    irq_in[7] = 1'b1; settle();
    rd(2'd2, d); chk("R8 source 7", d, 32'h7);
    irq_in[5] = 1'b1; irq_in[6] = 1'b1; settle();
    rd(2'd2, d); chk("R8 source 5 lowest", d, 32'h5);
    irq_in[5] = 1'b0; settle();
    wr(2'd1, ~32'h20); settle();
    rd(2'd1, d); chk("R7 single clear", d, 32'hC0);
    rd(2'd2, d); chk("R8 source 6", d, 32'h6);
    clean();
    rd(2'd2, d); chk("R8 source none", d, 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(2'd0, 32'h30);
    irq_in[4] = 1'b1; irq_in[5] = 1'b1; settle();
    irq_in = IDLE; settle();
    wr(2'd1, ~32'h10);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1234_5678;
    @(negedge clk); bus_wr = 1'b0;
    chk("R10 dip low", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R10 re-raise", {31'h0, cpu_irq}, 32'h1);
    wr(2'd1, 32'h0); settle();
    chk("R9 held after clear", {31'h0, cpu_irq}, 32'h1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2;
    @(negedge clk); bus_wr = 1'b0;
    chk("R10 low after ack", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R10 stays low", {31'h0, cpu_irq}, 32'h0);
    clean();
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R1 enable width", d, 32'hFF);
    irq_in[31:8] = 24'hFF_FFFF; settle();
    irq_in[31:8] = 24'h0; settle();
    rd(2'd1, d); chk("R1 upper inputs ignored", d, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R1 pending width", d, 32'h0);
    clean();
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(2'd0, 32'h4);
    irq_in[2] = 1'b1; settle();
    rd(2'd3, d); chk("R11 reserved zero", d, 32'h0);
    rd(2'd0, d); chk("R11 enable read", d, 32'h4);
    clean();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_level();
    t_gate();
    t_keep();
    t_prio();
    t_ack();
    t_upper();
    t_rsvd();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule